// File: doc/BRIEF.md
# Compact Multi-Cycle Load/Store Core

This block is a small sequential processor for a 32-bit load/store instruction set. It fetches one instruction word at a time over a single memory port, decodes and checks it, executes it, and then fetches again. It has six general registers, R0 to R5. Register index 6 returns the program counter: instructions can read it but never write it. The instruction set covers signed arithmetic, shifts, bitwise and logical operations, register move, compare-and-branch, load immediate, one load and one store, and a system call.

Each instruction word holds, from bit 31 down: opcode in [31:27], extension in [26:24], first register in [23:21], second register in [20:18], third register in [17:15], and a 15-bit field in [14:0]. The 15-bit field is either a byte address or an immediate. The system call talks to the outside through two valid/ready channels, one for input and one for output, and stalls until each transfer completes. Halting and faulting both stop the core permanently, until the next reset.

Top module: `lsx_core`

## Requirements
- R1: While `rst` is high, the core clears the program counter and R0 to R5 and clears `div_err`. On the first cycle after `rst` falls, it requests a read at byte address 0 with `mem_we` low, and `halted`, `fault`, `io_in_ready` and `io_out_valid` are all low.
- R2: Every memory request uses a byte address that is a multiple of 4. Read data is taken from `mem_rdata` in the cycle after the request.
- R3: The three-register operations compute reg2 op reg3 as signed 32-bit values and write the result to reg1. The opcodes are: plus=0, minus=1, times=2 (low 32 bits), div=3, mod=4, band=9, bor=10, bxor=11. The logical operations and=13 and or=14 give 1 or 0, treating any nonzero value as true.
- R4: The unary operations read reg2 and write reg1. They are neg=5, abs=6, bneg=12 (bitwise invert), not=15 (1 if the value is zero, else 0) and move=22. For these operations, reg3, the extension and the 15-bit field have no effect.
- R5: shl=7 shifts reg2 left and shr=8 shifts it right, filling with zeros, by the unsigned count held in reg3. A count of 32 or more gives 0.
- R6: div truncates toward zero, and mod takes the sign of the dividend. Dividing the most negative value by -1 gives the most negative value, with remainder 0. A zero divisor writes 0 to reg1 and sets `div_err`, which stays set until reset.
- R7: The branches eq=16, neq=17, le=18, lt=19, ge=20 and gt=21 compare reg1 with reg2 as signed values. A taken branch loads the program counter with the 15-bit field; otherwise the counter advances by 4.
- R8: Reading register index 6 returns the byte address of the instruction being executed. Every instruction that is not a taken branch advances the counter by 4.
- R9: lw=23 loads the word at the byte address in the field into reg1. sw=25 stores reg1 there. li=24 writes the field, zero-extended, into reg1; the field need not be aligned.
- R10: sys=26 with extension 0 (integer) or 2 (character) raises `io_in_ready`. `io_in_char` is high only for extension 2. The core holds there, with no memory request, until `io_in_valid`, then writes `io_in_data` to reg1.
- R11: sys with extension 1 (integer) or 3 (character) presents reg1 on `io_out_data` with `io_out_valid` high. `io_out_char` is high only for extension 3. Valid and data stay steady until `io_out_ready`.
- R12: sys with extension 4 sets `halted`. After that the core issues no memory or I/O activity, and `halted` stays high until reset.
- R13: An invalid word sets `fault` and stops the core before the instruction has any effect. A word is invalid when any of these holds:
  - the opcode is 27 or above;
  - a sys instruction has an extension above 4;
  - a register field the instruction uses holds 7;
  - a load, store or branch has a field that is not a multiple of 4;
  - the instruction would write reg1 with reg1 equal to 6.
  Fields an instruction does not use never make it invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| io_in_ready | output | 1 | Core waits for an input value |
| io_in_char | output | 1 | Pending input is a character |
| io_in_valid | input | 1 | Input value present |
| io_in_data | input | 32 | Input value |
| io_out_valid | output | 1 | Output value present |
| io_out_char | output | 1 | Output value is a character |
| io_out_data | output | 32 | Output value |
| io_out_ready | input | 1 | Output value accepted |
| halted | output | 1 | Halt system call executed |
| fault | output | 1 | Invalid instruction met |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The hardest situations to reach from the ports are the ones inside the datapath: an operation result, the current counter value, or a rejected instruction. None of these leaves the core unless the program itself moves it to memory. Each stimulus is therefore a short program that loads operands with lw, runs the instruction under test, and stores the outcome with sw to a known word. The bench then checks the modelled memory. For a fault, the program puts a marker store right after the bad word, and the bench checks that the marker never lands. I/O stalls are reached by having the bench model hold back `io_in_valid` and `io_out_ready` for several cycles, while watching that no memory request slips out during the wait.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

  localparam int FLD_W = 15;
  localparam int REG_W = 3;
  localparam int OPC_W = 5;
  localparam int EXT_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_MUL  = 5'd2,  OP_DIV  = 5'd3,
    OP_REM  = 5'd4,  OP_NEG  = 5'd5,  OP_ABS  = 5'd6,  OP_SLL  = 5'd7,
    OP_SRL  = 5'd8,  OP_AND  = 5'd9,  OP_OR   = 5'd10, OP_XOR  = 5'd11,
    OP_INV  = 5'd12, OP_LAND = 5'd13, OP_LOR  = 5'd14, OP_LNOT = 5'd15,
    OP_BEQ  = 5'd16, OP_BNE  = 5'd17, OP_BLE  = 5'd18, OP_BLT  = 5'd19,
    OP_BGE  = 5'd20, OP_BGT  = 5'd21, OP_MOV  = 5'd22, OP_LDW  = 5'd23,
    OP_LDI  = 5'd24, OP_STW  = 5'd25, OP_SYS  = 5'd26
  } op_e;

  typedef enum logic [2:0] {
    K_ALU, K_BR, K_LW, K_LI, K_SW, K_SYS
  } kind_e;

  typedef struct packed {
    logic [OPC_W-1:0] op;
    logic [EXT_W-1:0] ext;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [REG_W-1:0] rc;
    logic [FLD_W-1:0] fld;
  } instr_t;

  typedef enum logic [2:0] {
    S_FETCH, S_LATCH, S_EXEC, S_LOAD, S_IN, S_OUT, S_HALT, S_FAULT
  } state_e;

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
  import lsx_pkg::*;
#(
  parameter int PC_IDX  = 6,
  parameter int BAD_IDX = 7
) (
  input  instr_t ins,
  output kind_e  kind,
  output logic   legal
);

  logic use_ra, use_rb, use_rc, use_addr, wr_ra, bad_op;

  always_comb begin
    kind     = K_ALU;
    use_ra   = 1'b0;
    use_rb   = 1'b0;
    use_rc   = 1'b0;
    use_addr = 1'b0;
    wr_ra    = 1'b0;
    bad_op   = 1'b0;
    case (ins.op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_REM, OP_SLL, OP_SRL,
      OP_AND, OP_OR, OP_XOR, OP_LAND, OP_LOR: begin
        use_ra = 1'b1; use_rb = 1'b1; use_rc = 1'b1; wr_ra = 1'b1;
      end
      OP_NEG, OP_ABS, OP_INV, OP_LNOT, OP_MOV: begin
        use_ra = 1'b1; use_rb = 1'b1; wr_ra = 1'b1;
      end
      OP_BEQ, OP_BNE, OP_BLE, OP_BLT, OP_BGE, OP_BGT: begin
        kind = K_BR; use_ra = 1'b1; use_rb = 1'b1; use_addr = 1'b1;
      end
      OP_LDW: begin
        kind = K_LW; use_ra = 1'b1; wr_ra = 1'b1; use_addr = 1'b1;
      end
      OP_LDI: begin
        kind = K_LI; use_ra = 1'b1; wr_ra = 1'b1;
      end
      OP_STW: begin
        kind = K_SW; use_ra = 1'b1; use_addr = 1'b1;
      end
      OP_SYS: begin
        kind   = K_SYS;
        use_ra = (ins.ext < 3'd4);
        wr_ra  = (ins.ext == 3'd0) || (ins.ext == 3'd2);
        bad_op = (ins.ext > 3'd4);
      end
      default: bad_op = 1'b1;
    endcase
  end

  always_comb begin
    legal = !bad_op
         && !(use_ra && ins.ra == REG_W'(BAD_IDX))
         && !(use_rb && ins.rb == REG_W'(BAD_IDX))
         && !(use_rc && ins.rc == REG_W'(BAD_IDX))
         && !(use_addr && ins.fld[1:0] != 2'b00)
         && !(wr_ra && ins.ra == REG_W'(PC_IDX));
  end

endmodule

// File: rtl/lsx_alu.sv
module lsx_alu
  import lsx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPC_W-1:0] op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  res,
  output logic             div0,
  output logic             taken
);

  localparam int SHW = $clog2(XLEN);
  localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};

  logic signed [XLEN-1:0] sa, sb;
  logic [XLEN-1:0] quo, rem;
  logic            b_zero, ovf, sh_big;

  assign sa     = $signed(a);
  assign sb     = $signed(b);
  assign b_zero = (b == '0);
  assign ovf    = (a == MINV) && (b == '1);
  assign sh_big = (b >= XLEN'(XLEN));

  always_comb begin
    if (b_zero) begin
      quo = '0;
      rem = '0;
    end else if (ovf) begin
      quo = MINV;
      rem = '0;
    end else begin
      quo = sa / sb;
      rem = sa % sb;
    end
  end

  always_comb begin
    res  = '0;
    div0 = 1'b0;
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_DIV:  begin res = quo; div0 = b_zero; end
      OP_REM:  begin res = rem; div0 = b_zero; end
      OP_NEG:  res = '0 - a;
      OP_ABS:  res = a[XLEN-1] ? ('0 - a) : a;
      OP_SLL:  res = sh_big ? '0 : (a << b[SHW-1:0]);
      OP_SRL:  res = sh_big ? '0 : (a >> b[SHW-1:0]);
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INV:  res = ~a;
      OP_LAND: res = ((|a) && (|b)) ? ONE : '0;
      OP_LOR:  res = ((|a) || (|b)) ? ONE : '0;
      OP_LNOT: res = (|a) ? '0 : ONE;
      OP_MOV:  res = a;
      default: res = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_BEQ:  taken = (a == b);
      OP_BNE:  taken = (a != b);
      OP_BLE:  taken = (sa <= sb);
      OP_BLT:  taken = (sa <  sb);
      OP_BGE:  taken = (sa >= sb);
      OP_BGT:  taken = (sa >  sb);
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsx_regfile.sv
module lsx_regfile #(
  parameter int XLEN = 32,
  parameter int NGPR = 6,
  parameter int RW   = 3,
  parameter int NRD  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [RW-1:0]        waddr,
  input  logic [XLEN-1:0]      wdata,
  input  logic [XLEN-1:0]      pc_val,
  input  logic [NRD*RW-1:0]    rd_idx,
  output logic [NRD*XLEN-1:0]  rd_val
);

  localparam int NSLOT = 1 << RW;

  logic [XLEN-1:0] gpr  [NGPR];
  logic [XLEN-1:0] slot [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < NGPR) begin : g_gpr
      assign slot[s] = gpr[s];
    end else begin : g_pc
      assign slot[s] = pc_val;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_val[p*XLEN +: XLEN] = slot[rd_idx[p*RW +: RW]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NGPR; i++) gpr[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NGPR; i++)
        if (waddr == RW'(i)) gpr[i] <= wdata;
    end
  end

endmodule

// File: rtl/lsx_core.sv
module lsx_core
  import lsx_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = FLD_W,
  parameter int NGPR = 6
) (
  input  logic            clk,
  input  logic            rst,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            io_in_ready,
  output logic            io_in_char,
  input  logic            io_in_valid,
  input  logic [XLEN-1:0] io_in_data,
  output logic            io_out_valid,
  output logic            io_out_char,
  output logic [XLEN-1:0] io_out_data,
  input  logic            io_out_ready,
  output logic            halted,
  output logic            fault,
  output logic            div_err
);

  localparam int NRD  = 3;
  localparam logic [AW-1:0] STEP = AW'(4);

  state_e          state;
  logic [AW-1:0]   pc, pc_nx;
  instr_t          ir;
  kind_e           kind;
  logic            legal;
  logic [XLEN-1:0] pc_x, v_ra, v_rb, v_rc;
  logic [XLEN-1:0] alu_a, alu_b, alu_res;
  logic            alu_div0, br_taken;
  logic [NRD*XLEN-1:0] rd_val;
  logic            rf_we;
  logic [XLEN-1:0] rf_wdata;
  logic            exec_ok, sys_rd, sys_wr;

  assign pc_nx = pc + STEP;
  assign pc_x  = {{(XLEN-AW){1'b0}}, pc};

  lsx_decode u_dec (
    .ins   (ir),
    .kind  (kind),
    .legal (legal)
  );

  lsx_regfile #(
    .XLEN (XLEN),
    .NGPR (NGPR),
    .RW   (REG_W),
    .NRD  (NRD)
  ) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (ir.ra),
    .wdata  (rf_wdata),
    .pc_val (pc_x),
    .rd_idx ({ir.rc, ir.rb, ir.ra}),
    .rd_val (rd_val)
  );

  assign v_ra = rd_val[0*XLEN +: XLEN];
  assign v_rb = rd_val[1*XLEN +: XLEN];
  assign v_rc = rd_val[2*XLEN +: XLEN];

  assign alu_a = (kind == K_BR) ? v_ra : v_rb;
  assign alu_b = (kind == K_BR) ? v_rb : v_rc;

  lsx_alu #(.XLEN(XLEN)) u_alu (
    .op    (ir.op),
    .a     (alu_a),
    .b     (alu_b),
    .res   (alu_res),
    .div0  (alu_div0),
    .taken (br_taken)
  );

  assign exec_ok = (state == S_EXEC) && legal;
  assign sys_rd  = (ir.ext == 3'd0) || (ir.ext == 3'd2);
  assign sys_wr  = (ir.ext == 3'd1) || (ir.ext == 3'd3);

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = alu_res;
    case (state)
      S_EXEC: begin
        if (legal && kind == K_ALU) rf_we = 1'b1;
        if (legal && kind == K_LI) begin
          rf_we    = 1'b1;
          rf_wdata = {{(XLEN-FLD_W){1'b0}}, ir.fld};
        end
      end
      S_LOAD: begin
        rf_we    = 1'b1;
        rf_wdata = mem_rdata;
      end
      S_IN: begin
        rf_we    = io_in_valid;
        rf_wdata = io_in_data;
      end
      default: rf_we = 1'b0;
    endcase
  end

  assign mem_req   = (state == S_FETCH) || (exec_ok && (kind == K_LW || kind == K_SW));
  assign mem_we    = exec_ok && (kind == K_SW);
  assign mem_addr  = (state == S_FETCH) ? pc : AW'(ir.fld);
  assign mem_wdata = v_ra;

  assign io_in_ready  = (state == S_IN);
  assign io_in_char   = ir.ext[1];
  assign io_out_valid = (state == S_OUT);
  assign io_out_char  = ir.ext[1];
  assign io_out_data  = v_ra;
  assign halted       = (state == S_HALT);
  assign fault        = (state == S_FAULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_FETCH;
      pc      <= '0;
      ir      <= '0;
      div_err <= 1'b0;
    end else begin
      case (state)
        S_FETCH: state <= S_LATCH;
        S_LATCH: begin
          ir    <= instr_t'(mem_rdata);
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (!legal) begin
            state <= S_FAULT;
          end else begin
            case (kind)
              K_ALU: begin
                pc    <= pc_nx;
                state <= S_FETCH;
                if (alu_div0) div_err <= 1'b1;
              end
              K_BR: begin
                pc    <= br_taken ? AW'(ir.fld) : pc_nx;
                state <= S_FETCH;
              end
              K_LW: state <= S_LOAD;
              K_SYS: begin
                if (sys_rd)      state <= S_IN;
                else if (sys_wr) state <= S_OUT;
                else             state <= S_HALT;
              end
              default: begin
                pc    <= pc_nx;
                state <= S_FETCH;
              end
            endcase
          end
        end
        S_LOAD: begin
          pc    <= pc_nx;
          state <= S_FETCH;
        end
        S_IN: if (io_in_valid) begin
          pc    <= pc_nx;
          state <= S_FETCH;
        end
        S_OUT: if (io_out_ready) begin
          pc    <= pc_nx;
          state <= S_FETCH;
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/lsx_core_chk.sv
module lsx_core_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr,
  input logic            io_in_ready,
  input logic            io_in_valid,
  input logic            io_out_valid,
  input logic [XLEN-1:0] io_out_data,
  input logic            io_out_ready,
  input logic            halted,
  input logic            fault,
  input logic            div_err
);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_DIVERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    div_err |=> div_err); // R6

  AST_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (io_in_ready && !io_in_valid) |=> (io_in_ready && !mem_req)); // R10

  AST_IO_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(io_in_ready && io_out_valid)); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (io_out_valid && !io_out_ready) |=> (io_out_valid && $stable(io_out_data))); // R11

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R12

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_req && !io_in_ready && !io_out_valid && !fault)); // R12

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault); // R13

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!mem_req && !io_in_ready && !io_out_valid)); // R13

endmodule

bind lsx_core lsx_core_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .io_in_ready  (io_in_ready),
  .io_in_valid  (io_in_valid),
  .io_out_valid (io_out_valid),
  .io_out_data  (io_out_data),
  .io_out_ready (io_out_ready),
  .halted       (halted),
  .fault        (fault),
  .div_err      (div_err)
);

// File: tb/lsx_core_tb_top.sv
module lsx_core_tb_top;

  localparam int MW       = 128;
  localparam int IN_DLY   = 6;
  localparam int OUT_DLY  = 3;
  localparam int MAXCYC   = 400;
  localparam int A_OP     = 32'h100;
  localparam int B_OP     = 32'h104;
  localparam int RES      = 32'h108;
  localparam int RES2     = 32'h10C;

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  32'd5,        32'd7,        32'd12},        // R3 plus
    '{5'd1,  32'd3,        32'd10,       32'hFFFFFFF9},  // R3 minus
    '{5'd2,  32'hFFFFFFFD, 32'd4,        32'hFFFFFFF4},  // R3 times
    '{5'd3,  32'hFFFFFFF9, 32'd2,        32'hFFFFFFFD},  // R6 div
    '{5'd4,  32'hFFFFFFF9, 32'd2,        32'hFFFFFFFF},  // R6 mod
    '{5'd3,  32'h80000000, 32'hFFFFFFFF, 32'h80000000},  // R6 overflow
    '{5'd4,  32'h80000000, 32'hFFFFFFFF, 32'd0},         // R6 overflow
    '{5'd5,  32'd216,      32'd9,        32'hFFFFFF28},  // R4 neg
    '{5'd6,  32'hFFFFFFFB, 32'd9,        32'd5},         // R4 abs
    '{5'd7,  32'd1,        32'd31,       32'h80000000},  // R5 shl
    '{5'd8,  32'h80000000, 32'd31,       32'd1},         // R5 shr
    '{5'd7,  32'd1,        32'd40,       32'd0},         // R5 large count
    '{5'd9,  32'hF0F0,     32'hFF00,     32'hF000},      // R3 band
    '{5'd10, 32'hF0F0,     32'hFF00,     32'hFFF0},      // R3 bor
    '{5'd11, 32'hF0F0,     32'hFF00,     32'h0FF0},      // R3 bxor
    '{5'd12, 32'd0,        32'd3,        32'hFFFFFFFF},  // R4 bneg
    '{5'd13, 32'd3,        32'd0,        32'd0},         // R3 and
    '{5'd14, 32'd0,        32'd5,        32'd1},         // R3 or
    '{5'd15, 32'd0,        32'd7,        32'd1},         // R4 not
    '{5'd22, 32'h1234,     32'd7,        32'h1234},      // R4 move
    '{5'd3,  32'd9,        32'd0,        32'd0}          // R6 div by zero
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        io_in_ready, io_in_char;
  logic        io_in_valid = 1'b0;
  logic [31:0] io_in_data = '0;
  logic        io_out_valid, io_out_char;
  logic [31:0] io_out_data;
  logic        io_out_ready = 1'b0;
  logic        halted, fault, div_err;

  always #5 clk = ~clk;

  lsx_core dut_i (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .io_in_ready  (io_in_ready),
    .io_in_char   (io_in_char),
    .io_in_valid  (io_in_valid),
    .io_in_data   (io_in_data),
    .io_out_valid (io_out_valid),
    .io_out_char  (io_out_char),
    .io_out_data  (io_out_data),
    .io_out_ready (io_out_ready),
    .halted       (halted),
    .fault        (fault),
    .div_err      (div_err)
  );

  logic [31:0] mem [MW];
  logic [31:0] in_vals [2];
  logic [31:0] out_log [4];
  logic        out_chr [4];
  logic        in_chr  [4];
  int          in_n, out_n, in_wait, out_wait, in_cycles;
  logic        stall_bad;
  int          n_chk = 0;
  int          n_fail = 0;

  function automatic logic [31:0] enc(int op, int ext, int ra, int rb, int rc, int fld);
    return {op[4:0], ext[2:0], ra[2:0], rb[2:0], rc[2:0], fld[14:0]};
  endfunction

  function automatic string req_of(logic [4:0] op);
    case (op)
      5'd3, 5'd4:             return "R6";
      5'd7, 5'd8:             return "R5";
      5'd5, 5'd6, 5'd12,
      5'd15, 5'd22:           return "R4";
      default:                return "R3";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) mem[i] = '0;
  endtask

  task automatic put(int addr, logic [31:0] w);
    mem[addr[8:2]] = w;
  endtask

  function automatic logic [31:0] peek(int addr);
    return mem[addr[8:2]];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    io_in_valid = 1'b0;
    io_out_ready = 1'b0;
    in_n = 0; out_n = 0; in_wait = 0; out_wait = 0; in_cycles = 0;
    stall_bad = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic service();
    io_in_valid  = 1'b0;
    io_out_ready = 1'b0;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[8:2]] = mem_wdata;
      else        mem_rdata = mem[mem_addr[8:2]];
    end
    if (io_in_ready) begin
      in_cycles++;
      if (mem_req) stall_bad = 1'b1;
      in_wait++;
      if (in_wait > IN_DLY) begin
        io_in_valid = 1'b1;
        io_in_data  = in_vals[in_n % 2];
        in_chr[in_n % 4] = io_in_char;
        in_n++;
        in_wait = 0;
      end
    end
    if (io_out_valid) begin
      if (mem_req) stall_bad = 1'b1;
      out_wait++;
      if (out_wait > OUT_DLY) begin
        io_out_ready = 1'b1;
        out_log[out_n % 4] = io_out_data;
        out_chr[out_n % 4] = io_out_char;
        out_n++;
        out_wait = 0;
      end
    end
  endtask

  task automatic run();
    int cyc = 0;
    while (!halted && !fault && cyc < MAXCYC) begin
      service();
      @(negedge clk);
      cyc++;
    end
    io_in_valid  = 1'b0;
    io_out_ready = 1'b0;
    if (cyc >= MAXCYC) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAXCYC);
    end
  endtask

  task automatic alu_prog(logic [4:0] op);
    clear_mem();
    put(0,  enc(23, 0, 1, 0, 0, A_OP));
    put(4,  enc(23, 0, 2, 0, 0, B_OP));
    put(8,  enc(op, 0, 3, 1, 2, 0));
    put(12, enc(25, 0, 3, 0, 0, RES));
    put(16, enc(26, 4, 0, 0, 0, 0));
  endtask

  task automatic branch_test(int op, logic [31:0] a, logic [31:0] b, logic [31:0] exp);
    clear_mem();
    put(0,  enc(23, 0, 1, 0, 0, A_OP));
    put(4,  enc(23, 0, 2, 0, 0, B_OP));
    put(8,  enc(op, 0, 1, 2, 0, 24));
    put(12, enc(24, 0, 3, 0, 0, 1));
    put(16, enc(25, 0, 3, 0, 0, RES));
    put(20, enc(26, 4, 0, 0, 0, 0));
    put(24, enc(24, 0, 3, 0, 0, 2));
    put(28, enc(25, 0, 3, 0, 0, RES));
    put(32, enc(26, 4, 0, 0, 0, 0));
    put(A_OP, a);
    put(B_OP, b);
    do_reset();
    run();
    chk("R7 branch outcome", peek(RES), exp);
  endtask

  logic [31:0] bad [6];

  initial begin
    // R1: reset state and first fetch
    clear_mem();
    do_reset();
    chk("R1 reset outputs",
        {31'd0, mem_req && !mem_we && mem_addr == 15'd0 && !halted && !fault
                && !div_err && !io_in_ready && !io_out_valid},
        32'd1);

    // R3 R4 R5 R6: operation table, one program per row
    for (int k = 0; k < NV; k++) begin
      alu_prog(VEC[k].op);
      put(A_OP, VEC[k].a);
      put(B_OP, VEC[k].b);
      do_reset();
      run();
      chk(req_of(VEC[k].op), peek(RES), VEC[k].exp);
      if (k == 0) begin
        chk("R6 flag clear after normal op", {31'd0, div_err}, 32'd0);
        chk("R12 halt reached", {31'd0, halted}, 32'd1);
      end
      if (k == NV - 1) chk("R6 div_err set", {31'd0, div_err}, 32'd1);
    end

    // R7: signed compare and branch
    branch_test(19, 32'hFFFFFFFF, 32'd1, 32'd2);
    branch_test(19, 32'd1, 32'hFFFFFFFF, 32'd1);
    branch_test(16, 32'd5, 32'd5, 32'd2);
    branch_test(17, 32'd5, 32'd5, 32'd1);
    branch_test(21, 32'd6, 32'd5, 32'd2);

    // R8: register 6 reads the current instruction address
    clear_mem();
    put(0,  enc(24, 0, 0, 0, 0, 0));
    put(4,  enc(24, 0, 0, 0, 0, 0));
    put(8,  enc(22, 0, 1, 6, 0, 0));
    put(12, enc(25, 0, 1, 0, 0, RES));
    put(16, enc(25, 0, 6, 0, 0, RES2));
    put(20, enc(26, 4, 0, 0, 0, 0));
    do_reset();
    run();
    chk("R8 move from pc", peek(RES), 32'd8);
    chk("R8 store pc", peek(RES2), 32'd16);

    // R9: immediate zero-extension, store and load round trip
    clear_mem();
    put(0,  enc(24, 5, 1, 7, 7, 32'h7FFF));
    put(4,  enc(25, 0, 1, 0, 0, RES));
    put(8,  enc(23, 0, 2, 0, 0, RES));
    put(12, enc(0,  0, 3, 2, 2, 0));
    put(16, enc(25, 0, 3, 0, 0, RES2));
    put(20, enc(26, 4, 0, 0, 0, 0));
    do_reset();
    run();
    chk("R9 li zero-extended", peek(RES), 32'h00007FFF);
    chk("R9 lw then add", peek(RES2), 32'h0000FFFE);

    // R10 R11: system-call I/O with delayed partners
    clear_mem();
    in_vals[0] = 32'hFFFFFF85;
    in_vals[1] = 32'h00000041;
    put(0,  enc(26, 0, 1, 0, 0, 0));
    put(4,  enc(26, 1, 1, 0, 0, 0));
    put(8,  enc(26, 2, 2, 0, 0, 0));
    put(12, enc(26, 3, 2, 0, 0, 0));
    put(16, enc(26, 4, 0, 0, 0, 0));
    do_reset();
    run();
    chk("R10 integer input kind", {31'd0, in_chr[0]}, 32'd0);
    chk("R10 char input kind", {31'd0, in_chr[1]}, 32'd1);
    chk("R10 stall length", in_cycles, 2 * (IN_DLY + 1));
    chk("R10 no memory while waiting", {31'd0, stall_bad}, 32'd0);
    chk("R11 integer out value", out_log[0], 32'hFFFFFF85);
    chk("R11 integer out kind", {31'd0, out_chr[0]}, 32'd0);
    chk("R11 char out value", out_log[1], 32'h00000041);
    chk("R11 char out kind", {31'd0, out_chr[1]}, 32'd1);
    chk("R11 output count", out_n, 2);
    chk("R12 halt after io", {31'd0, halted && !fault}, 32'd1);

    // R13: invalid words fault before any effect
    bad[0] = enc(27, 0, 1, 1, 1, 0);
    bad[1] = enc(26, 5, 1, 0, 0, 0);
    bad[2] = enc(0,  0, 1, 7, 2, 0);
    bad[3] = enc(23, 0, 1, 0, 0, 32'h102);
    bad[4] = enc(22, 0, 6, 1, 0, 0);
    bad[5] = enc(26, 0, 6, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      clear_mem();
      put(0,  bad[k]);
      put(4,  enc(24, 0, 1, 0, 0, 1));
      put(8,  enc(25, 0, 1, 0, 0, RES));
      put(12, enc(26, 4, 0, 0, 0, 0));
      do_reset();
      run();
      chk("R13 fault raised", {30'd0, fault, halted}, 32'd2);
      chk("R13 no later store", peek(RES), 32'd0);
    end

    // R13 R4: unused fields holding 7 or odd values stay legal
    clear_mem();
    put(0,  enc(15, 7, 1, 2, 7, 32'h7FFF));
    put(4,  enc(25, 0, 1, 0, 0, RES));
    put(8,  enc(26, 4, 7, 7, 7, 32'h7FFF));
    do_reset();
    run();
    chk("R13 unused fields ignored", {30'd0, fault, halted}, 32'd1);
    chk("R4 not ignores reg3 and field", peek(RES), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule